// File: doc/BRIEF.md
# Clock Reference Mode Controller

This block is the mode controller of a telecom timing loop. It chooses whether the output clock runs free on the local oscillator, holds the last learned frequency from stored history, or locks to one of six external references. While it works towards a lock it passes through a reference-switching state, and it reports its decision as a state code, the index of the chosen reference and a packed status byte. Frequency measurement, qualification, the loop filter and the oscillator steering all sit outside the block. They reach it only through availability flags, a qualify-pass pulse, a qualify-fail pulse and a history-valid level.

The mode request is a 4-bit code. It comes either from three pins, read with a leading zero, or from a configuration register. A source-select bit chooses between the two. In automatic mode a missing reference is replaced by the best available one, ranked by a 4-bit priority per reference. In revertive mode the controller returns to a reference that was lost once that reference comes back. Holdover is allowed only while valid history exists. The configuration register that feeds the priority inputs is meant to reset them to 8, 7, 6, 5, 4 and 3 for references 1 to 6.

Top module: `refmode_ctrl`

## Requirements
- R1: While reset is held, and right after it is released, the block is in free-run (state code 0), with reference output 0 and status byte {history, 3'b000, 4'b1001}.
- R2: Mode codes map as follows: 0000 free-run, 0011 holdover, 0001/0010 reference 1/2, and 0100/0101/0110/0111 references 3/4/5/6. Any code with bit 3 set is ignored and the last valid code stays in force.
- R3: With the source-select input at 0 the 3-bit pin code (extended with a leading 0) is used. With it at 1 the register code is used and the pins have no effect.
- R4: Code 0000 puts the block in free-run at the next clock edge from any state. From free-run, holdover is entered directly only on a change to code 0011 while history is valid; otherwise the block stays in free-run.
- R5: A change to a reference code moves the block to switching (state 1), and the reference output shows the target. A qualify-pass pulse while the target is still usable and the code is unchanged moves it to locked (state 2).
- R6: A reference is usable only when it is available and its priority is nonzero. In automatic mode an unusable target is replaced by the usable reference with the largest priority; on equal priority the lower index wins.
- R7: When no reference is usable in automatic mode, the block goes to holdover (state 3), or to free-run if history is not valid.
- R8: In manual mode, a target that is unusable on entry, becomes unusable during evaluation, or receives a qualify-fail pulse sends the block to holdover. From holdover, the block re-enters switching once the commanded reference is usable.
- R9: When the locked reference becomes unusable, the block goes to switching on the best usable reference if automatic mode is on and one exists; otherwise it goes to holdover.
- R10: With revertive mode on, when a reference lost while locked becomes usable again, the block goes from locked or holdover to switching on that reference.
- R11: Holdover is never kept or entered in a cycle where history is not valid; the block falls to free-run instead.
- R12: The status byte is: bit 7 = history valid; bits 6:4 = locked reference (0 unless locked); bits 3:0 = 1001 in free-run, 1000 in holdover, 0000 in switching and 0001 in locked.
- R13: A history-clear pulse drops the history flag in the same cycle. The flag stays low until the history-valid input has gone low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_code_i | input | 3 | Mode code from pins |
| reg_code_i | input | 4 | Mode code from register |
| use_reg_i | input | 1 | 1 selects the register code |
| ref_avail_i | input | 6 | Per-reference availability, bit 0 = reference 1 |
| ref_prio_i | input | 24 | Priorities, nibble k-1 = reference k |
| auto_en_i | input | 1 | Automatic failover enable |
| revert_en_i | input | 1 | Revertive return enable |
| qual_ok_i | input | 1 | Target qualified pulse |
| qual_fail_i | input | 1 | Target failed qualification pulse |
| hist_ok_i | input | 1 | Holdover history valid |
| hist_clr_i | input | 1 | History clear pulse |
| state_o | output | 2 | 0 free-run, 1 switching, 2 locked, 3 holdover |
| ref_o | output | 3 | Target or locked reference, 0 = none |
| status_o | output | 8 | Packed status byte |

## Verification
A vector table steps the block through every code value from both the pins and the register. Among these is an illegal code, which separates ignored codes from decoded ones, and pin changes made while the register is selected, which show that the pins are masked. Directed sequences then remove references one at a time, during switching and while locked. Two references given equal priority show whether the tie rule holds, and a zero priority shows whether that reference is excluded. Running the same losses with the automatic, manual and revertive settings separates failover, holdover entry and return. The history input is dropped and cleared in different states to separate the holdover gate from the free-run fallback.

// File: rtl/refmode_pkg.sv
package refmode_pkg;
  localparam int RM_NREF   = 6;
  localparam int RM_PRIO_W = 4;
  localparam int RM_CODE_W = 4;
  localparam int RM_PIN_W  = RM_CODE_W - 1;
  localparam int RM_IDX_W  = $clog2(RM_NREF + 1);

  typedef enum logic [1:0] {
    ST_FREE   = 2'd0,
    ST_SWITCH = 2'd1,
    ST_LOCK   = 2'd2,
    ST_HOLD   = 2'd3
  } rm_state_e;

  typedef enum logic [1:0] {
    CMD_FREE = 2'd0,
    CMD_HOLD = 2'd1,
    CMD_REF  = 2'd2
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e             kind;
    logic [RM_IDX_W-1:0]   ref_idx;
  } cmd_t;

  localparam logic [3:0] NIB_FREE   = 4'b1001;
  localparam logic [3:0] NIB_HOLD   = 4'b1000;
  localparam logic [3:0] NIB_SWITCH = 4'b0000;
  localparam logic [3:0] NIB_LOCK   = 4'b0001;
endpackage

// File: rtl/refmode_decode.sv
module refmode_decode
  import refmode_pkg::*;
(
  input  logic [RM_PIN_W-1:0]  pin_code_i,
  input  logic [RM_CODE_W-1:0] reg_code_i,
  input  logic                 use_reg_i,
  output logic                 code_ok_o,
  output cmd_t                 cmd_o
);
  logic [RM_CODE_W-1:0] raw;

  always_comb begin
    raw = use_reg_i ? reg_code_i : {1'b0, pin_code_i};
    // codes with the top bit set are outside the map and ignored
    code_ok_o = (raw[RM_CODE_W-1] == 1'b0);
    cmd_o.kind    = CMD_FREE;
    cmd_o.ref_idx = '0;
    case (raw[2:0])
      3'b000: cmd_o.kind = CMD_FREE;
      3'b011: cmd_o.kind = CMD_HOLD;
      3'b001: begin
        cmd_o.kind    = CMD_REF;
        cmd_o.ref_idx = RM_IDX_W'(1);
      end
      3'b010: begin
        cmd_o.kind    = CMD_REF;
        cmd_o.ref_idx = RM_IDX_W'(2);
      end
      default: begin
        cmd_o.kind    = CMD_REF;
        cmd_o.ref_idx = RM_IDX_W'(raw[1:0]) + RM_IDX_W'(3);
      end
    endcase
  end
endmodule

// File: rtl/refmode_pick.sv
module refmode_pick #(
  parameter int NREF   = 6,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 3
) (
  input  logic [NREF-1:0]        avail_i,
  input  logic [NREF*PRIO_W-1:0] prio_i,
  output logic [NREF-1:0]        usable_o,
  output logic [IDX_W-1:0]       best_o,
  output logic                   any_o
);
  genvar g;
  generate
    for (g = 0; g < NREF; g++) begin : g_use
      assign usable_o[g] = avail_i[g] && (prio_i[g*PRIO_W +: PRIO_W] != '0);
    end
  endgenerate

  logic [PRIO_W-1:0] best_p;

  always_comb begin
    best_p = '0;
    best_o = '0;
    // strict compare: on equal priority the lower index is kept
    for (int i = 0; i < NREF; i++) begin
      if (usable_o[i] && (prio_i[i*PRIO_W +: PRIO_W] > best_p)) begin
        best_p = prio_i[i*PRIO_W +: PRIO_W];
        best_o = IDX_W'(i + 1);
      end
    end
  end

  assign any_o = |usable_o;
endmodule

// File: rtl/refmode_hist.sv
module refmode_hist (
  input  logic clk,
  input  logic rst_n,
  input  logic hist_ok_i,
  input  logic hist_clr_i,
  output logic hist_eff_o
);
  logic cleared_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cleared_q <= 1'b0;
    end else if (hist_clr_i) begin
      cleared_q <= 1'b1;
    end else if (!hist_ok_i) begin
      cleared_q <= 1'b0;
    end
  end

  assign hist_eff_o = hist_ok_i && !hist_clr_i && !cleared_q;
endmodule

// File: rtl/refmode_ctrl.sv
module refmode_ctrl
  import refmode_pkg::*;
#(
  parameter int NREF   = RM_NREF,
  parameter int PRIO_W = RM_PRIO_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [RM_PIN_W-1:0]    pin_code_i,
  input  logic [RM_CODE_W-1:0]   reg_code_i,
  input  logic                   use_reg_i,
  input  logic [NREF-1:0]        ref_avail_i,
  input  logic [NREF*PRIO_W-1:0] ref_prio_i,
  input  logic                   auto_en_i,
  input  logic                   revert_en_i,
  input  logic                   qual_ok_i,
  input  logic                   qual_fail_i,
  input  logic                   hist_ok_i,
  input  logic                   hist_clr_i,
  output logic [1:0]             state_o,
  output logic [RM_IDX_W-1:0]    ref_o,
  output logic [7:0]             status_o
);
  localparam int IDX_W = RM_IDX_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  // sub-blocks
  logic             code_ok;
  cmd_t             cmd_dec;
  logic [NREF-1:0]  usable;
  logic [IDX_W-1:0] best_idx;
  logic             any_usable;
  logic             hist_eff;

  refmode_decode u_dec (
    .pin_code_i (pin_code_i),
    .reg_code_i (reg_code_i),
    .use_reg_i  (use_reg_i),
    .code_ok_o  (code_ok),
    .cmd_o      (cmd_dec)
  );

  refmode_pick #(.NREF(NREF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
    .avail_i  (ref_avail_i),
    .prio_i   (ref_prio_i),
    .usable_o (usable),
    .best_o   (best_idx),
    .any_o    (any_usable)
  );

  refmode_hist u_hist (
    .clk        (clk),
    .rst_n      (rst_sn),
    .hist_ok_i  (hist_ok_i),
    .hist_clr_i (hist_clr_i),
    .hist_eff_o (hist_eff)
  );

  // state registers
  rm_state_e        st_q, st_d;
  logic [IDX_W-1:0] ref_q, ref_d;
  logic [IDX_W-1:0] lost_q, lost_d;
  cmd_t             cmd_q;
  cmd_t             cmd_cur;
  logic             cmd_chg;
  logic [IDX_W-1:0] tgt_new;

  function automatic logic usable_at(input logic [IDX_W-1:0] idx,
                                     input logic [NREF-1:0] use_v);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NREF; i++) begin
      if (idx == IDX_W'(i + 1)) r = use_v[i];
    end
    return r;
  endfunction

  assign cmd_cur = code_ok ? cmd_dec : cmd_q;
  assign cmd_chg = code_ok && (cmd_dec != cmd_q);

  // target chosen when a reference code is commanded
  always_comb begin
    tgt_new = '0;
    if (cmd_cur.kind == CMD_REF) begin
      if (usable_at(cmd_cur.ref_idx, usable)) tgt_new = cmd_cur.ref_idx;
      else if (auto_en_i && any_usable)       tgt_new = best_idx;
    end
  end

  always_comb begin
    st_d   = st_q;
    ref_d  = ref_q;
    lost_d = lost_q;
    if (cmd_cur.kind == CMD_FREE) begin
      st_d   = ST_FREE;
      ref_d  = '0;
      lost_d = '0;
    end else begin
      case (st_q)
        ST_FREE: begin
          lost_d = '0;
          if (cmd_chg) begin
            if (cmd_cur.kind == CMD_HOLD) begin
              if (hist_eff) st_d = ST_HOLD;
            end else begin
              st_d  = ST_SWITCH;
              ref_d = tgt_new;
            end
          end
        end
        ST_SWITCH: begin
          if (cmd_chg) begin
            lost_d = '0;
            if (cmd_cur.kind == CMD_HOLD) begin
              st_d  = hist_eff ? ST_HOLD : ST_FREE;
              ref_d = '0;
            end else begin
              ref_d = tgt_new;
            end
          end else if (!usable_at(ref_q, usable)) begin
            if (auto_en_i && any_usable) begin
              ref_d = best_idx;
            end else begin
              st_d  = hist_eff ? ST_HOLD : ST_FREE;
              ref_d = '0;
            end
          end else if (qual_fail_i) begin
            st_d  = hist_eff ? ST_HOLD : ST_FREE;
            ref_d = '0;
          end else if (qual_ok_i) begin
            st_d = ST_LOCK;
          end
        end
        ST_LOCK: begin
          if (cmd_chg) begin
            lost_d = '0;
            if (cmd_cur.kind == CMD_HOLD) begin
              st_d  = hist_eff ? ST_HOLD : ST_FREE;
              ref_d = '0;
            end else begin
              st_d  = ST_SWITCH;
              ref_d = tgt_new;
            end
          end else if (!usable_at(ref_q, usable)) begin
            lost_d = ref_q;
            if (auto_en_i && any_usable) begin
              st_d  = ST_SWITCH;
              ref_d = best_idx;
            end else begin
              st_d  = hist_eff ? ST_HOLD : ST_FREE;
              ref_d = '0;
            end
          end else if (revert_en_i && (lost_q != '0) && (lost_q != ref_q) &&
                       usable_at(lost_q, usable)) begin
            st_d   = ST_SWITCH;
            ref_d  = lost_q;
            lost_d = '0;
          end
        end
        default: begin // ST_HOLD
          ref_d = '0;
          if (!hist_eff) begin
            st_d   = ST_FREE;
            lost_d = '0;
          end else if (cmd_chg) begin
            lost_d = '0;
            if (cmd_cur.kind == CMD_REF) begin
              st_d  = ST_SWITCH;
              ref_d = tgt_new;
            end
          end else if (cmd_cur.kind == CMD_REF) begin
            if (revert_en_i && (lost_q != '0) && usable_at(lost_q, usable)) begin
              st_d   = ST_SWITCH;
              ref_d  = lost_q;
              lost_d = '0;
            end else if (usable_at(cmd_cur.ref_idx, usable)) begin
              st_d  = ST_SWITCH;
              ref_d = cmd_cur.ref_idx;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q          <= ST_FREE;
      ref_q         <= '0;
      lost_q        <= '0;
      cmd_q.kind    <= CMD_FREE;
      cmd_q.ref_idx <= '0;
    end else begin
      st_q   <= st_d;
      ref_q  <= ref_d;
      lost_q <= lost_d;
      if (code_ok) cmd_q <= cmd_dec;
    end
  end

  // outputs
  logic [3:0] nib;
  always_comb begin
    case (st_q)
      ST_FREE:   nib = NIB_FREE;
      ST_HOLD:   nib = NIB_HOLD;
      ST_SWITCH: nib = NIB_SWITCH;
      default:   nib = NIB_LOCK;
    endcase
  end

  assign state_o  = st_q;
  assign ref_o    = ref_q;
  assign status_o = {hist_eff, (st_q == ST_LOCK) ? ref_q : 3'b000, nib};
endmodule

// File: rtl/refmode_ctrl_chk.sv
module refmode_ctrl_chk
  import refmode_pkg::*;
#(
  parameter int NREF   = RM_NREF,
  parameter int PRIO_W = RM_PRIO_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [RM_PIN_W-1:0]    pin_code_i,
  input logic [RM_CODE_W-1:0]   reg_code_i,
  input logic                   use_reg_i,
  input logic [NREF*PRIO_W-1:0] ref_prio_i,
  input logic [1:0]             state_o,
  input logic [RM_IDX_W-1:0]    ref_o,
  input logic [7:0]             status_o
);
  logic [RM_CODE_W-1:0] code_eff;
  logic [PRIO_W-1:0]    prio_at;

  assign code_eff = use_reg_i ? reg_code_i : {1'b0, pin_code_i};

  always_comb begin
    prio_at = '0;
    for (int i = 0; i < NREF; i++) begin
      if (ref_o == RM_IDX_W'(i + 1)) prio_at = ref_prio_i[i*PRIO_W +: PRIO_W];
    end
  end

  p_idle_no_ref_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 || state_o == 2'd3) |-> (ref_o == '0));

  p_free_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (code_eff == '0) |=> (state_o == 2'd0));

  p_lock_ref_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |-> (ref_o != '0 && int'(ref_o) <= NREF));

  p_lock_via_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && $past(state_o) != 2'd2) |-> ($past(state_o) == 2'd1));

  p_prio_zero_unused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && $past(state_o) == 2'd1) |-> ($past(prio_at) != '0));

  p_no_hold_wo_hist_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[7] |=> (state_o != 2'd3));
endmodule

bind refmode_ctrl refmode_ctrl_chk #(.NREF(NREF), .PRIO_W(PRIO_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pin_code_i (pin_code_i),
  .reg_code_i (reg_code_i),
  .use_reg_i  (use_reg_i),
  .ref_prio_i (ref_prio_i),
  .state_o    (state_o),
  .ref_o      (ref_o),
  .status_o   (status_o)
);

// File: tb/tb_refmode_ctrl.sv
module tb_refmode_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  pin;
  logic [3:0]  rcode;
  logic        use_reg;
  logic [5:0]  avail;
  logic [23:0] prio;
  logic        auto_en, rev_en, qual, fail, hist_ok, hist_clr;
  logic [1:0]  st;
  logic [2:0]  rf;
  logic [7:0]  stat;

  int checks = 0;
  int errors = 0;

  localparam logic [23:0] PRIO_DEF = {4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8};

  always #4 clk = ~clk;

  refmode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pin_code_i(pin), .reg_code_i(rcode),
    .use_reg_i(use_reg), .ref_avail_i(avail), .ref_prio_i(prio),
    .auto_en_i(auto_en), .revert_en_i(rev_en), .qual_ok_i(qual),
    .qual_fail_i(fail), .hist_ok_i(hist_ok), .hist_clr_i(hist_clr),
    .state_o(st), .ref_o(rf), .status_o(stat)
  );

  typedef struct packed {
    logic       use_reg;
    logic [2:0] pin;
    logic [3:0] rcode;
    logic       qual;
    logic [1:0] st;
    logic [2:0] rf;
    logic [7:0] stat;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 3'd1, 4'd0, 1'b0, 2'd1, 3'd1, 8'h80},
    '{1'b0, 3'd1, 4'd0, 1'b1, 2'd2, 3'd1, 8'h91},
    '{1'b0, 3'd2, 4'd0, 1'b0, 2'd1, 3'd2, 8'h80},
    '{1'b0, 3'd2, 4'd0, 1'b1, 2'd2, 3'd2, 8'hA1},
    '{1'b0, 3'd3, 4'd0, 1'b0, 2'd3, 3'd0, 8'h88},
    '{1'b0, 3'd0, 4'd0, 1'b0, 2'd0, 3'd0, 8'h89},
    '{1'b0, 3'd3, 4'd0, 1'b0, 2'd3, 3'd0, 8'h88},
    '{1'b0, 3'd4, 4'd0, 1'b0, 2'd1, 3'd3, 8'h80},
    '{1'b1, 3'd4, 4'd5, 1'b0, 2'd1, 3'd4, 8'h80},
    '{1'b1, 3'd0, 4'd5, 1'b1, 2'd2, 3'd4, 8'hC1},
    '{1'b1, 3'd0, 4'd8, 1'b0, 2'd2, 3'd4, 8'hC1},
    '{1'b1, 3'd0, 4'd7, 1'b0, 2'd1, 3'd6, 8'h80},
    '{1'b1, 3'd0, 4'd7, 1'b1, 2'd2, 3'd6, 8'hE1},
    '{1'b1, 3'd0, 4'd6, 1'b0, 2'd1, 3'd5, 8'h80},
    '{1'b1, 3'd0, 4'd0, 1'b0, 2'd0, 3'd0, 8'h89}
  };

  task automatic chk_now(input string tag, input logic [1:0] e_st,
                         input logic [2:0] e_rf, input logic [7:0] e_stat);
    checks++;
    if (st !== e_st || rf !== e_rf || stat !== e_stat) begin
      errors++;
      $display("FAIL %s: state=%0d exp %0d ref=%0d exp %0d status=%02h exp %02h",
               tag, st, e_st, rf, e_rf, stat, e_stat);
    end
  endtask

  task automatic tick(input string tag, input logic [1:0] e_st,
                      input logic [2:0] e_rf, input logic [7:0] e_stat);
    @(negedge clk);
    chk_now(tag, e_st, e_rf, e_stat);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin = 3'd0; rcode = 4'd0; use_reg = 1'b0;
    avail = 6'b111111; prio = PRIO_DEF; auto_en = 1'b0; rev_en = 1'b0;
    qual = 1'b0; fail = 1'b0; hist_ok = 1'b1; hist_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk_now("R1 in reset", 2'd0, 3'd0, 8'h89);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_now("R1 after reset", 2'd0, 3'd0, 8'h89);

    // vector table: decode (R2), source select (R3), free/hold (R4), lock (R5), status (R12)
    for (int i = 0; i < NV; i++) begin
      use_reg = TBL[i].use_reg;
      pin     = TBL[i].pin;
      rcode   = TBL[i].rcode;
      qual    = TBL[i].qual;
      tick($sformatf("R2 R3 R4 R5 R12 table row %0d", i), TBL[i].st, TBL[i].rf, TBL[i].stat);
    end
    qual = 1'b0; use_reg = 1'b0; pin = 3'd0; rcode = 4'd0;
    tick("R3 back to pins", 2'd0, 3'd0, 8'h89);

    // R6 automatic selection, tie and zero priority
    auto_en = 1'b1; prio[11:8] = 4'd7; avail = 6'b111110; pin = 3'd1;
    tick("R6 tie picks lower index", 2'd1, 3'd2, 8'h80);
    avail = 6'b111100;
    tick("R6 retarget on loss during switch", 2'd1, 3'd3, 8'h80);
    prio[11:8] = 4'd0;
    tick("R6 zero priority skipped", 2'd1, 3'd4, 8'h80);
    qual = 1'b1;
    tick("R5 lock after qualify", 2'd2, 3'd4, 8'hC1);
    qual = 1'b0;

    // R9 automatic failover from lock
    avail = 6'b110100;
    tick("R9 failover to best", 2'd1, 3'd5, 8'h80);
    qual = 1'b1;
    tick("R9 lock on failover ref", 2'd2, 3'd5, 8'hD1);
    qual = 1'b0;

    // R10 revertive return from lock
    rev_en = 1'b1; avail = 6'b111100;
    tick("R10 revert from lock", 2'd1, 3'd4, 8'h80);
    qual = 1'b1;
    tick("R10 relock", 2'd2, 3'd4, 8'hC1);
    qual = 1'b0;

    // R7 none usable, then R10 revert from holdover
    avail = 6'b000000;
    tick("R7 no usable ref goes holdover", 2'd3, 3'd0, 8'h88);
    avail = 6'b001000;
    tick("R10 revert from holdover", 2'd1, 3'd4, 8'h80);
    qual = 1'b1;
    tick("R10 relock after holdover", 2'd2, 3'd4, 8'hC1);
    qual = 1'b0; rev_en = 1'b0;

    // R11 history loss in holdover, R13 history clear
    avail = 6'b000000;
    tick("R7 holdover again", 2'd3, 3'd0, 8'h88);
    hist_ok = 1'b0;
    tick("R11 holdover falls to free-run", 2'd0, 3'd0, 8'h09);
    hist_ok = 1'b1;
    tick("R13 history back", 2'd0, 3'd0, 8'h89);
    hist_clr = 1'b1;
    #1;
    chk_now("R13 clear drops flag at once", 2'd0, 3'd0, 8'h09);
    tick("R13 clear held", 2'd0, 3'd0, 8'h09);
    hist_clr = 1'b0;
    tick("R13 flag stays low", 2'd0, 3'd0, 8'h09);
    hist_ok = 1'b0;
    tick("R13 history input low", 2'd0, 3'd0, 8'h09);
    hist_ok = 1'b1;
    tick("R13 flag returns after refill", 2'd0, 3'd0, 8'h89);

    // R8 manual mode
    auto_en = 1'b0; avail = 6'b111111; prio = PRIO_DEF; pin = 3'd2;
    tick("R8 manual switch", 2'd1, 3'd2, 8'h80);
    fail = 1'b1;
    tick("R8 qualify fail to holdover", 2'd3, 3'd0, 8'h88);
    fail = 1'b0;
    tick("R8 commanded ref reacquired", 2'd1, 3'd2, 8'h80);
    avail = 6'b111101;
    tick("R8 lost during evaluation", 2'd3, 3'd0, 8'h88);
    pin = 3'd4; avail = 6'b111001;
    tick("R8 unusable target on entry", 2'd1, 3'd0, 8'h80);
    tick("R8 unusable target to holdover", 2'd3, 3'd0, 8'h88);

    // R9 manual loss while locked
    avail = 6'b111111;
    tick("R8 target usable again", 2'd1, 3'd3, 8'h80);
    qual = 1'b1;
    tick("R5 manual lock", 2'd2, 3'd3, 8'hB1);
    qual = 1'b0; avail = 6'b111011;
    tick("R9 manual loss to holdover", 2'd3, 3'd0, 8'h88);

    // R4 free-run forcing and gated holdover
    pin = 3'd0;
    tick("R4 code zero forces free-run", 2'd0, 3'd0, 8'h89);
    hist_ok = 1'b0; pin = 3'd3;
    tick("R4 holdover refused without history", 2'd0, 3'd0, 8'h09);

    // R7 no usable ref and no history
    auto_en = 1'b1; avail = 6'b000000; pin = 3'd1;
    tick("R7 switch with no target", 2'd1, 3'd0, 8'h00);
    tick("R7 falls to free-run without history", 2'd0, 3'd0, 8'h09);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule